// File: doc/BRIEF.md
# GPIO Output Control Bank

This block is a parallel I/O controller for a port of 32 lines, reached through a simple register bus. The bus has an address, write data, a write strobe, a read strobe and read data. Each line holds three control bits: output enable, output level and open-drain select. Each control vector is changed only through a pair of addresses. One address sets the bits written as 1 and the other clears them, so one bit can change without a read-modify-write. A status address reads the vector back.

A fourth vector, the write mask, is changed the same way. A store to the output-level status address then loads only the unmasked lines, all in a single cycle. A parallel bus spread over the port can therefore move to a new value without passing through a mixed state, which a set followed by a clear would produce. Output enable and output level can be written while a line is still an input, so the first level the line drives is known before the line is enabled.

The block drives a drive-enable and an output value per line to a pad model. A line in open-drain mode drives the pad only when its level bit is 0. When the level bit is 1 the line is released to a pull-up. The pin levels are synchronised through two flops and can be read back as feedback.

There is no sequencing state in this block. Every vector is a register updated on each clock edge from the current bus command, and reads return data in the same cycle as the read strobe.

Top module: `gpio_out_bank`

Address map (5-bit word address): 0x00 enable set, 0x01 enable clear, 0x02 enable status, 0x04 level set, 0x05 level clear, 0x06 level status / masked direct write, 0x08 mask set, 0x09 mask clear, 0x0A mask status, 0x0C open-drain set, 0x0D open-drain clear, 0x0E open-drain status, 0x10 pin status.

## Requirements
- R1: After reset, the enable, level, mask and open-drain vectors are all zero, so every line is an input, and `pad_oe` and `pad_out` are zero.
- R2: A write to 0x00 sets the enable bits that are 1 in the data, and a write to 0x01 clears them. Bits written 0 keep their value. The new value reads back at 0x02 after the write edge.
- R3: A write to 0x04 sets the level bits that are 1 in the data, and a write to 0x05 clears them. Bits written 0 are unchanged. The level vector reads back at 0x06. It can be written while the enable bit is 0.
- R4: A write to 0x06 replaces exactly the level bits whose mask bit is 1. All other level bits keep their value.
- R5: A write to 0x08 sets mask bits and a write to 0x09 clears them. The mask reads back at 0x0A. Because the mask is zero after reset, a direct write at 0x06 then changes nothing.
- R6: A write to 0x0C sets open-drain bits and a write to 0x0D clears them. The open-drain vector reads back at 0x0E.
- R7: For each line, `pad_out` equals the level bit. `pad_oe` equals enable AND (NOT open-drain OR NOT level), so a line in open-drain mode is never driven high.
- R8: Address 0x10 returns `pin_in` as it was two clock edges earlier, through a two-flop synchroniser.
- R9: Set and clear addresses, unmapped addresses, and any read with `rd_en` low return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Read data, valid in the cycle of `rd_en` |
| pin_in | input | 32 | Sampled pin levels from the pad |
| pad_oe | output | 32 | Per-line pad drive enable |
| pad_out | output | 32 | Per-line pad output value |

## Verification
The bench runs a long pseudo-random sequence over every set, clear and direct-write address and compares all four status vectors and both pad buses against a model after each command. A design that let zero bits of a set or clear word through would wipe unrelated lines. A design that ignored the mask would move lines that must hold, and this shows most clearly right after reset, when the mask is empty. Every combination of enable, open-drain and level is tried on a walking line, which catches a pad that drives an open-drain line high or drives a line that is not enabled. Pin feedback is sampled one edge and two edges after a change, so a synchroniser of the wrong depth shows up.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_OE_SET   = 5'h00,
        A_OE_CLR   = 5'h01,
        A_OE_STAT  = 5'h02,
        A_LVL_SET  = 5'h04,
        A_LVL_CLR  = 5'h05,
        A_LVL_STAT = 5'h06,
        A_MSK_SET  = 5'h08,
        A_MSK_CLR  = 5'h09,
        A_MSK_STAT = 5'h0A,
        A_OD_SET   = 5'h0C,
        A_OD_CLR   = 5'h0D,
        A_OD_STAT  = 5'h0E,
        A_PIN_STAT = 5'h10
    } reg_addr_e;
endpackage

// File: rtl/gpio_setclr_vec.sv
module gpio_setclr_vec #(
    parameter int              W          = 32,
    parameter int              AW         = 5,
    parameter logic [AW-1:0]   SET_A      = '0,
    parameter logic [AW-1:0]   CLR_A      = '0,
    parameter logic [AW-1:0]   DIR_A      = '0,
    parameter bit              HAS_DIRECT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  dir_mask,
    output logic [W-1:0]  vec_q
);
    logic          hit_set, hit_clr, hit_dir;
    logic [W-1:0]  vec_d;

    assign hit_set = wr_en && (wr_addr == SET_A);
    assign hit_clr = wr_en && (wr_addr == CLR_A);

    generate
        if (HAS_DIRECT) begin : g_direct
            assign hit_dir = wr_en && (wr_addr == DIR_A);
        end else begin : g_no_direct
            assign hit_dir = 1'b0;
        end
    endgenerate

    always_comb begin
        vec_d = vec_q;
        if (hit_set)      vec_d = vec_q | wr_data;
        else if (hit_clr) vec_d = vec_q & ~wr_data;
        else if (hit_dir) vec_d = (vec_q & ~dir_mask) | (wr_data & dir_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    // R2/R3/R5/R6: set address raises every written-one bit
    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SET_A) |=> ((vec_q & $past(wr_data)) == $past(wr_data)));
    // R2/R3/R5/R6: zero bits of a set word keep their value
    assert_set_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SET_A) |=> (((vec_q ^ $past(vec_q)) & ~$past(wr_data)) == '0));
    // R2/R3/R5/R6: clear address drops every written-one bit
    assert_clr_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CLR_A) |=> ((vec_q & $past(wr_data)) == '0));
    // R4: direct write never moves a masked-off bit
    assert_direct_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_DIRECT && wr_en && wr_addr == DIR_A) |=> (((vec_q ^ $past(vec_q)) & ~$past(dir_mask)) == '0));
    // R5: idle bus leaves vector unchanged
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vec_q));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int W = 32
) (
    input  logic [W-1:0] oe_q,
    input  logic [W-1:0] lvl_q,
    input  logic [W-1:0] od_q,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_line
            assign pad_oe[g]  = oe_q[g] & (~od_q[g] | ~lvl_q[g]);
            assign pad_out[g] = lvl_q[g];
        end
    endgenerate
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            pin_q  <= '0;
        end else begin
            stage1 <= pin_in;
            pin_q  <= stage1;
        end
    end

    // R8: second stage follows the first one edge later
    assert_sync_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pin_q == $past(stage1)));
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NLINES-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NLINES-1:0] rd_data,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pad_oe,
    output logic [NLINES-1:0] pad_out
);
    localparam logic [NLINES-1:0] ZERO_V = '0;

    logic [NLINES-1:0] oe_q, lvl_q, msk_q, od_q, pin_q;
    logic [NLINES-1:0] rd_mux;

    gpio_setclr_vec #(.W(NLINES), .AW(ADDR_W), .SET_A(A_OE_SET), .CLR_A(A_OE_CLR),
                      .DIR_A(A_OE_STAT), .HAS_DIRECT(1'b0)) u_oe (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dir_mask(ZERO_V), .vec_q(oe_q));

    gpio_setclr_vec #(.W(NLINES), .AW(ADDR_W), .SET_A(A_LVL_SET), .CLR_A(A_LVL_CLR),
                      .DIR_A(A_LVL_STAT), .HAS_DIRECT(1'b1)) u_lvl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dir_mask(msk_q), .vec_q(lvl_q));

    gpio_setclr_vec #(.W(NLINES), .AW(ADDR_W), .SET_A(A_MSK_SET), .CLR_A(A_MSK_CLR),
                      .DIR_A(A_MSK_STAT), .HAS_DIRECT(1'b0)) u_msk (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dir_mask(ZERO_V), .vec_q(msk_q));

    gpio_setclr_vec #(.W(NLINES), .AW(ADDR_W), .SET_A(A_OD_SET), .CLR_A(A_OD_CLR),
                      .DIR_A(A_OD_STAT), .HAS_DIRECT(1'b0)) u_od (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dir_mask(ZERO_V), .vec_q(od_q));

    gpio_pad_drive #(.W(NLINES)) u_pad (
        .oe_q(oe_q), .lvl_q(lvl_q), .od_q(od_q), .pad_oe(pad_oe), .pad_out(pad_out));

    gpio_pin_sync #(.W(NLINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_q(pin_q));

    always_comb begin
        case (rd_addr)
            A_OE_STAT:  rd_mux = oe_q;
            A_LVL_STAT: rd_mux = lvl_q;
            A_MSK_STAT: rd_mux = msk_q;
            A_OD_STAT:  rd_mux = od_q;
            A_PIN_STAT: rd_mux = pin_q;
            default:    rd_mux = '0;
        endcase
        rd_data = rd_en ? rd_mux : '0;
    end

    // R7: no line is driven unless enabled
    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~oe_q) == '0));
    // R7: an open-drain line never drives a high level
    assert_od_no_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & od_q) == '0));
    // R9: idle read port returns zero
    assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
    // R5: mask empty means a direct write leaves the level vector alone
    assert_empty_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_LVL_STAT && msk_q == '0) |=> $stable(lvl_q));
endmodule

// File: tb/test_gpio_out_bank.sv
`timescale 1ns/1ps
module test_gpio_out_bank;
    import gpio_bank_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_oe, pad_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] oe_m, lvl_m, msk_m, od_m;
    logic [31:0] seed;

    always #2.5 clk = ~clk;

    gpio_out_bank i_gpio_out_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
        .pad_oe(pad_oe), .pad_out(pad_out));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        #0.5;
        d = rd_data;
        rd_en = 1'b0; rd_addr = '0;
        #0.1;
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check_all(input string ctx);
        logic [31:0] v;
        bus_rd(A_OE_STAT, v);  chk({ctx, " R2 enable status"}, v, oe_m);
        bus_rd(A_LVL_STAT, v); chk({ctx, " R3 level status"}, v, lvl_m);
        bus_rd(A_MSK_STAT, v); chk({ctx, " R5 mask status"}, v, msk_m);
        bus_rd(A_OD_STAT, v);  chk({ctx, " R6 open-drain status"}, v, od_m);
        chk({ctx, " R7 pad_oe"}, pad_oe, oe_m & (~od_m | ~lvl_m));
        chk({ctx, " R7 pad_out"}, pad_out, lvl_m);
    endtask

    task automatic model_apply(input logic [4:0] a, input logic [31:0] d);
        case (a)
            A_OE_SET:   oe_m  = oe_m | d;
            A_OE_CLR:   oe_m  = oe_m & ~d;
            A_LVL_SET:  lvl_m = lvl_m | d;
            A_LVL_CLR:  lvl_m = lvl_m & ~d;
            A_LVL_STAT: lvl_m = (lvl_m & ~msk_m) | (d & msk_m);
            A_MSK_SET:  msk_m = msk_m | d;
            A_MSK_CLR:  msk_m = msk_m & ~d;
            A_OD_SET:   od_m  = od_m | d;
            A_OD_CLR:   od_m  = od_m & ~d;
            default: ;
        endcase
    endtask

    task automatic do_wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr(a, d);
        model_apply(a, d);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [4:0] ops [9];
        logic [4:0] zero_addrs [9];
        ops = '{A_OE_SET, A_OE_CLR, A_LVL_SET, A_LVL_CLR, A_LVL_STAT,
                A_MSK_SET, A_MSK_CLR, A_OD_SET, A_OD_CLR};
        zero_addrs = '{A_OE_SET, A_OE_CLR, A_LVL_SET, A_LVL_CLR, A_MSK_SET,
                       A_MSK_CLR, A_OD_SET, A_OD_CLR, 5'h1F};
        oe_m = '0; lvl_m = '0; msk_m = '0; od_m = '0;
        seed = 32'h1234_5678;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_all("R1 reset");
        chk("R1 pad_oe zero", pad_oe, 32'h0);

        // R5: direct write with empty mask changes nothing
        do_wr(A_LVL_STAT, 32'hFFFF_FFFF);
        bus_rd(A_LVL_STAT, v);
        chk("R5 empty mask direct write", v, 32'h0);

        // R3: preset level while line is input
        do_wr(A_LVL_SET, 32'h0000_00F0);
        chk("R3 preset no drive", pad_oe, 32'h0);
        chk("R3 preset pad_out", pad_out, 32'h0000_00F0);

        // R4: masked direct write
        do_wr(A_MSK_SET, 32'h0000_FF00);
        do_wr(A_LVL_STAT, 32'hAAAA_5555);
        bus_rd(A_LVL_STAT, v);
        chk("R4 masked direct write", v, 32'h0000_55F0);
        chk("R4 model agree", v, lvl_m);

        // R7: every combination of enable/open-drain/level on a walking line
        for (int ln = 0; ln < 32; ln += 5) begin
            for (int c = 0; c < 8; c++) begin
                logic [31:0] bit1;
                bit1 = 32'h1 << ln;
                do_wr(c[0] ? A_OE_SET  : A_OE_CLR,  bit1);
                do_wr(c[1] ? A_OD_SET  : A_OD_CLR,  bit1);
                do_wr(c[2] ? A_LVL_SET : A_LVL_CLR, bit1);
                chk("R7 line drive enable", (pad_oe >> ln) & 32'h1,
                    {31'h0, c[0] & (~c[1] | ~c[2])});
                chk("R7 line value", (pad_out >> ln) & 32'h1, {31'h0, c[2]});
            end
        end

        // R2 R3 R4 R5 R6 R7: pseudo-random sweep over all write addresses
        for (int k = 0; k < 180; k++) begin
            seed = next_rand(seed);
            do_wr(ops[k % 9], seed);
            check_all("sweep");
        end

        // R9: set/clear/unmapped read zero; read with rd_en low is zero
        do_wr(A_OE_SET, 32'hFFFF_FFFF);
        for (int z = 0; z < 9; z++) begin
            bus_rd(zero_addrs[z], v);
            chk("R9 write-only address reads zero", v, 32'h0);
        end
        rd_addr = A_OE_STAT; #0.5;
        chk("R9 no strobe reads zero", rd_data, 32'h0);
        rd_addr = '0;

        // R8: two-edge pin feedback latency
        for (int p = 0; p < 4; p++) begin
            logic [31:0] oldp, newp;
            seed = next_rand(seed);
            @(negedge clk);
            oldp = pin_in;
            pin_in = '0;
            @(negedge clk); @(negedge clk); @(negedge clk);
            oldp = 32'h0;
            newp = seed;
            pin_in = newp;
            @(negedge clk);
            bus_rd(A_PIN_STAT, v);
            chk("R8 one edge still old", v, oldp);
            @(negedge clk);
            bus_rd(A_PIN_STAT, v);
            chk("R8 two edges new", v, newp);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule